// File: doc/BRIEF.md
# Parallel RGB Pixel Bus Receiver

This block sits behind the pins of a display controller that accepts a free-running dot clock, frame and line sync pulses, a data-enable strobe and an 18-bit parallel data bus. Every input is sampled on the rising edge of the dot clock. A two-bit width code picks how pixel colour arrives on the bus: all 18 bits at once, a 16-bit 5:6:5 word on a split set of bus bits, or a 6-bit bus that carries red, green and blue in three enabled beats. Whatever the width, the block emits full 18-bit pixels, red in bits 17..12, green in 11..6 and blue in 5..0. Each pixel comes with a one-cycle valid strobe, a zero-based row and a zero-based column.

The block also follows the vertical timing of each frame in units of lines. A frame runs from one VSYNC pulse to the next. A line runs from an HSYNC pulse to the next HSYNC or VSYNC. A line that sees data-enable is a display line. Lines without enable before the first display line form the back porch, and lines without enable after it form the front porch. When the next VSYNC arrives, the block judges the closed frame against the porch and display-length limits and updates a sticky error output.

Top module: `pixel_bus_rx`

## Requirements
- R1: With width code 00, every clock with enable high yields a pixel equal to busData[17:0]. pixValid rises for one cycle in the clock after that sample.
- R2: With width code 01, red is taken from busData[17:13], green from busData[11:6] and blue from busData[5:1]. Bits 12 and 0 are ignored. Red and blue are widened to six bits by repeating their most significant bit as the new least significant bit. One pixel is emitted per enabled clock.
- R3: With width code 10, busData[17:12] carries red, then green, then blue on three consecutive enabled clocks, and one pixel is emitted after the third. HSYNC or VSYNC discards a partial triplet, so the next enabled beat is red again.
- R4: With width code 11, no pixel is ever emitted, whatever enable does. Line and frame tracking continues as normal.
- R5: pixCol is the number of pixels already emitted in the current line. It returns to 0 at every HSYNC or VSYNC.
- R6: pixRow is the number of display lines since the last VSYNC that come before the current line. Porch lines do not advance it.
- R7: A line with no enable is counted as back porch if no display line has yet occurred in the frame, and as front porch otherwise.
- R8: One clock after a VSYNC that follows an earlier VSYNC, timingErr is set if the back porch was outside 2..14 lines, the front porch was outside 2..14 lines, their sum was not 16, or the frame had more than 320 display lines. Otherwise it is cleared. It keeps its value in every other cycle.
- R9: After reset, pixValid and timingErr are 0. The first VSYNC after reset leaves timingErr at 0, whatever lines came before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMode | input | 2 | Width code: 00 18-bit, 01 16-bit, 10 6-bit, 11 off |
| vsyncIn | input | 1 | Frame start pulse, one clock |
| hsyncIn | input | 1 | Line start pulse, one clock |
| enableIn | input | 1 | Data enable; the bus is valid while high |
| busData | input | 18 | Parallel pixel bus |
| pixValid | output | 1 | One-cycle strobe for a new pixel |
| pixData | output | 18 | Pixel, 6:6:6, red in the top bits |
| pixRow | output | ROW_W (9) | Display row of the pixel |
| pixCol | output | COL_W (10) | Column of the pixel within its line |
| timingErr | output | 1 | Result of the timing check on the last closed frame |

## Verification
The timing judgement only becomes visible at the VSYNC that ends a frame. Each limit is therefore reached by sweeping the back porch from 0 to 16 lines, with front porches that make the sum exactly 16, one short and one long. Frames of 320 and 321 display lines exercise the display-length bound. The discarded partial triplet in 6-bit mode needs a line that ends after one or two extra beats. The bench then checks that the first pixel of the following line is built only from that line's first three beats and has column 0.

// File: rtl/pixrx_pkg.sv
package pixrx_pkg;

  localparam int PIX_W  = 18;
  localparam int COMP_W = 6;

  typedef enum logic [1:0] {
    BUS_W18 = 2'b00,
    BUS_W16 = 2'b01,
    BUS_W6  = 2'b10,
    BUS_OFF = 2'b11
  } busMode_e;

  // strobes from the frame controller to the unpacker
  typedef struct packed {
    logic     lineStart;
    logic     beatEn;
    busMode_e mode;
  } rxCtl_t;

endpackage

// File: rtl/pixrx_frame_ctl.sv
module pixrx_frame_ctl
  import pixrx_pkg::*;
#(
  parameter int MAX_DISP  = 320,
  parameter int PORCH_MIN = 2,
  parameter int PORCH_MAX = 14,
  parameter int PORCH_SUM = 16,
  parameter int ROW_W     = 9,
  parameter int LINE_W    = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeIn,
  input  logic             vsyncIn,
  input  logic             hsyncIn,
  input  logic             enableIn,
  output rxCtl_t           ctl,
  output logic [ROW_W-1:0] rowIdx,
  output logic             timingErr
);

  localparam logic [LINE_W-1:0] CNT_MAX   = '1;
  localparam logic [LINE_W-1:0] LIM_LO    = LINE_W'(PORCH_MIN);
  localparam logic [LINE_W-1:0] LIM_HI    = LINE_W'(PORCH_MAX);
  localparam logic [LINE_W-1:0] DISP_HI   = LINE_W'(MAX_DISP);
  localparam logic [LINE_W:0]   SUM_REQ   = (LINE_W+1)'(PORCH_SUM);
  localparam logic [LINE_W-1:0] ROW_CLAMP = LINE_W'((1 << ROW_W) - 1);

  busMode_e modeSel;
  logic frameSeen, lineOpen, lineHadEn, timingErrQ;
  logic [LINE_W-1:0] bpCnt, dispCnt, fpCnt;
  logic [LINE_W-1:0] bpFin, dispFin, fpFin;
  logic closeBp, closeDisp, closeFp, frameBad;

  function automatic logic [LINE_W-1:0] satInc(input logic [LINE_W-1:0] v, input logic inc);
    return (inc && v != CNT_MAX) ? v + 1'b1 : v;
  endfunction

  assign modeSel = busMode_e'(modeIn);

  // classify the line that a sync pulse closes
  always_comb begin
    closeDisp = lineOpen & lineHadEn;
    closeBp   = lineOpen & ~lineHadEn & (dispCnt == '0);
    closeFp   = lineOpen & ~lineHadEn & (dispCnt != '0);
    bpFin     = satInc(bpCnt, closeBp);
    dispFin   = satInc(dispCnt, closeDisp);
    fpFin     = satInc(fpCnt, closeFp);
    frameBad  = (bpFin < LIM_LO) || (bpFin > LIM_HI) ||
                (fpFin < LIM_LO) || (fpFin > LIM_HI) ||
                (({1'b0, bpFin} + {1'b0, fpFin}) != SUM_REQ) ||
                (dispFin > DISP_HI);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSeen  <= 1'b0;
      lineOpen   <= 1'b0;
      lineHadEn  <= 1'b0;
      timingErrQ <= 1'b0;
      bpCnt      <= '0;
      dispCnt    <= '0;
      fpCnt      <= '0;
    end else if (vsyncIn) begin
      if (frameSeen) timingErrQ <= frameBad;
      frameSeen <= 1'b1;
      bpCnt     <= '0;
      dispCnt   <= '0;
      fpCnt     <= '0;
      lineOpen  <= hsyncIn;
      lineHadEn <= hsyncIn & enableIn;
    end else if (hsyncIn) begin
      bpCnt     <= bpFin;
      dispCnt   <= dispFin;
      fpCnt     <= fpFin;
      lineOpen  <= 1'b1;
      lineHadEn <= enableIn;
    end else if (enableIn && lineOpen) begin
      lineHadEn <= 1'b1;
    end
  end

  always_comb begin
    ctl.lineStart = vsyncIn | hsyncIn;
    ctl.beatEn    = enableIn & (modeSel != BUS_OFF);
    ctl.mode      = modeSel;
    rowIdx        = (dispCnt > ROW_CLAMP) ? ROW_CLAMP[ROW_W-1:0] : dispCnt[ROW_W-1:0];
  end

  assign timingErr = timingErrQ;

  // R8: the verdict only moves on a frame boundary
  assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncIn |=> $stable(timingErr));

  // R9: the first frame boundary after reset never raises the flag
  assert_first_vsync_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncIn && !frameSeen) |=> !timingErr);

  // R6: row numbering restarts at a frame boundary
  assert_row_restart_R6: assert property (@(posedge clk) disable iff (!rstN)
    (vsyncIn && !hsyncIn) |=> (rowIdx == '0));

  // R7: porch counters cleared at the frame boundary
  assert_porch_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    vsyncIn |=> (bpCnt == '0 && fpCnt == '0));

endmodule

// File: rtl/pixrx_unpack.sv
module pixrx_unpack
  import pixrx_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxCtl_t           ctl,
  input  logic [PIX_W-1:0] busData,
  input  logic [ROW_W-1:0] rowIdx,
  output logic             pixValid,
  output logic [PIX_W-1:0] pixData,
  output logic [ROW_W-1:0] pixRow,
  output logic [COL_W-1:0] pixCol
);

  localparam int BEATS_6 = 3;
  localparam logic [1:0] LAST_BEAT = 2'(BEATS_6 - 1);

  logic [1:0]        beatQ, beatCur;
  logic [COMP_W-1:0] redHold, grnHold;
  logic [COL_W-1:0]  colQ, colCur;
  logic [PIX_W-1:0]  pixNext;
  logic              emit;

  always_comb begin
    beatCur = ctl.lineStart ? 2'd0 : beatQ;
    colCur  = ctl.lineStart ? '0 : colQ;
    emit    = 1'b0;
    pixNext = busData;
    case (ctl.mode)
      BUS_W18: begin
        emit    = ctl.beatEn;
        pixNext = busData;
      end
      BUS_W16: begin
        emit    = ctl.beatEn;
        pixNext = {busData[17:13], busData[17], busData[11:6], busData[5:1], busData[5]};
      end
      BUS_W6: begin
        emit    = ctl.beatEn && (beatCur == LAST_BEAT);
        pixNext = {redHold, grnHold, busData[17:12]};
      end
      BUS_OFF: begin
        emit = 1'b0;
      end
      default: emit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatQ    <= '0;
      redHold  <= '0;
      grnHold  <= '0;
      colQ     <= '0;
      pixValid <= 1'b0;
      pixData  <= '0;
      pixRow   <= '0;
      pixCol   <= '0;
    end else begin
      pixValid <= emit;
      if (emit) begin
        pixData <= pixNext;
        pixRow  <= rowIdx;
        pixCol  <= colCur;
      end
      colQ <= emit ? colCur + 1'b1 : colCur;
      if (ctl.mode != BUS_W6) begin
        beatQ <= '0;
      end else if (ctl.beatEn) begin
        if (beatCur == 2'd0) redHold <= busData[17:12];
        if (beatCur == 2'd1) grnHold <= busData[17:12];
        beatQ <= (beatCur == LAST_BEAT) ? 2'd0 : beatCur + 2'd1;
      end else begin
        beatQ <= beatCur;
      end
    end
  end

  // R1: full-width beat passes straight through one cycle later
  assert_pass_through_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.beatEn && ctl.mode == BUS_W18) |=> (pixValid && pixData == $past(busData)));

  // R2: widened components repeat their top bit
  assert_widen_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.beatEn && ctl.mode == BUS_W16) |=>
      (pixValid && pixData[12] == pixData[17] && pixData[0] == pixData[5]));

  // R3: a beat at a line start is red and cannot complete a pixel
  assert_triplet_restart_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineStart && ctl.beatEn && ctl.mode == BUS_W6) |=> !pixValid);

  // R4: disabled width code emits nothing
  assert_off_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == BUS_OFF) |=> !pixValid);

  // R5: first pixel of a line sits in column zero
  assert_col_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineStart && ctl.beatEn && ctl.mode == BUS_W18) |=> (pixCol == '0));

endmodule

// File: rtl/pixel_bus_rx.sv
module pixel_bus_rx
  import pixrx_pkg::*;
#(
  parameter int MAX_DISP  = 320,
  parameter int PORCH_MIN = 2,
  parameter int PORCH_MAX = 14,
  parameter int PORCH_SUM = 16,
  parameter int COL_W     = 10,
  localparam int ROW_W    = $clog2(MAX_DISP),
  localparam int LINE_W   = $clog2(MAX_DISP + 2 * PORCH_MAX) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       busMode,
  input  logic             vsyncIn,
  input  logic             hsyncIn,
  input  logic             enableIn,
  input  logic [17:0]      busData,
  output logic             pixValid,
  output logic [17:0]      pixData,
  output logic [ROW_W-1:0] pixRow,
  output logic [COL_W-1:0] pixCol,
  output logic             timingErr
);

  rxCtl_t           ctl;
  logic [ROW_W-1:0] rowIdx;

  pixrx_frame_ctl #(
    .MAX_DISP (MAX_DISP),
    .PORCH_MIN(PORCH_MIN),
    .PORCH_MAX(PORCH_MAX),
    .PORCH_SUM(PORCH_SUM),
    .ROW_W    (ROW_W),
    .LINE_W   (LINE_W)
  ) uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .modeIn   (busMode),
    .vsyncIn  (vsyncIn),
    .hsyncIn  (hsyncIn),
    .enableIn (enableIn),
    .ctl      (ctl),
    .rowIdx   (rowIdx),
    .timingErr(timingErr)
  );

  pixrx_unpack #(
    .ROW_W(ROW_W),
    .COL_W(COL_W)
  ) uUnpack (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .busData (busData),
    .rowIdx  (rowIdx),
    .pixValid(pixValid),
    .pixData (pixData),
    .pixRow  (pixRow),
    .pixCol  (pixCol)
  );

endmodule

// File: tb/pixel_bus_rx_test.sv
module pixel_bus_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W      = 9;
  localparam int COL_W      = 10;
  localparam int WATCHDOG   = 150000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       busMode = 2'b00;
  logic             vsyncIn = 1'b0;
  logic             hsyncIn = 1'b0;
  logic             enableIn = 1'b0;
  logic [17:0]      busData = '0;
  logic             pixValid;
  logic [17:0]      pixData;
  logic [ROW_W-1:0] pixRow;
  logic [COL_W-1:0] pixCol;
  logic             timingErr;

  int    checks = 0;
  int    fails = 0;
  int    seed = 1;
  bit    done = 1'b0;
  logic  expErr = 1'b0;
  logic [1:0] modeNow = 2'b00;
  string curTag = "R1";
  logic [17+ROW_W+COL_W:0] expQ[$];

  pixel_bus_rx uut (
    .clk(clk), .rstN(rstN), .busMode(busMode), .vsyncIn(vsyncIn),
    .hsyncIn(hsyncIn), .enableIn(enableIn), .busData(busData),
    .pixValid(pixValid), .pixData(pixData), .pixRow(pixRow),
    .pixCol(pixCol), .timingErr(timingErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [17:0] pat();
    seed = seed + 1;
    return 18'((seed * 7919 + 12345) ^ (seed << 7));
  endfunction

  // pixel monitor, samples on the falling edge
  always @(negedge clk) begin
    if (rstN && !done && pixValid) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R4 unexpected pixel data=%h row=%0d col=%0d expected none",
                 pixData, pixRow, pixCol);
      end else begin
        logic [17+ROW_W+COL_W:0] e;
        e = expQ.pop_front();
        if ({pixData, pixRow, pixCol} !== e) begin
          fails++;
          $display("FAIL %s/R5/R6 pixel data=%h row=%0d col=%0d expected data=%h row=%0d col=%0d",
                   curTag, pixData, pixRow, pixCol, e[17+ROW_W+COL_W -: 18],
                   e[ROW_W+COL_W-1 -: ROW_W], e[COL_W-1:0]);
        end
      end
    end
  end

  task automatic cyc(input logic v, input logic h, input logic e, input logic [17:0] d);
    vsyncIn = v; hsyncIn = h; enableIn = e; busData = d;
    @(negedge clk);
  endtask

  task automatic checkErr(input string tag);
    checks++;
    if (timingErr !== expErr) begin
      fails++;
      $display("FAIL %s timingErr=%0b expected %0b", tag, timingErr, expErr);
    end
  endtask

  task automatic emptyLine();
    cyc(1'b0, 1'b1, 1'b0, pat());
    cyc(1'b0, 1'b0, 1'b0, pat());
  endtask

  task automatic pixLine(input int row, input int nPix, input int extra);
    logic [17:0] b0, b1, b2, ev;
    cyc(1'b0, 1'b1, 1'b0, 18'h0);
    for (int p = 0; p < nPix; p++) begin
      case (modeNow)
        2'b00: begin // R1
          b0 = pat();
          expQ.push_back({b0, ROW_W'(row), COL_W'(p)});
          cyc(1'b0, 1'b0, 1'b1, b0);
        end
        2'b01: begin // R2: 5:6:5 widened
          b0 = pat();
          ev = {b0[17:13], b0[17], b0[11:6], b0[5:1], b0[5]};
          expQ.push_back({ev, ROW_W'(row), COL_W'(p)});
          cyc(1'b0, 1'b0, 1'b1, b0);
        end
        2'b10: begin // R3: three beats
          b0 = pat(); b1 = pat(); b2 = pat();
          cyc(1'b0, 1'b0, 1'b1, b0);
          cyc(1'b0, 1'b0, 1'b1, b1);
          expQ.push_back({b0[17:12], b1[17:12], b2[17:12], ROW_W'(row), COL_W'(p)});
          cyc(1'b0, 1'b0, 1'b1, b2);
        end
        default: begin // R4: nothing expected
          cyc(1'b0, 1'b0, 1'b1, pat());
        end
      endcase
    end
    for (int k = 0; k < extra; k++) cyc(1'b0, 1'b0, 1'b1, pat());
    cyc(1'b0, 1'b0, 1'b0, 18'h0);
  endtask

  task automatic frame(input int bp, input int nl, input int fp, input int ppl,
                       input int extra, input logic [1:0] m, input string tag);
    busMode = m; modeNow = m; curTag = tag;
    cyc(1'b1, 1'b0, 1'b0, 18'h0);
    checkErr("R8");
    for (int i = 0; i < bp; i++) emptyLine();   // R7 back porch
    for (int r = 0; r < nl; r++) pixLine(r, ppl, (r == 0) ? extra : 0);
    for (int i = 0; i < fp; i++) emptyLine();   // R7 front porch
    checkErr("R8 hold");
    expErr = (bp < 2 || bp > 14 || fp < 2 || fp > 14 || bp + fp != 16 || nl > 320);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pixValid !== 1'b0 || timingErr !== 1'b0) begin
      fails++;
      $display("FAIL R9 reset pixValid=%0b timingErr=%0b expected 0 0", pixValid, timingErr);
    end
    rstN = 1'b1;
    @(negedge clk);
    // R9: stray lines before the first VSYNC must not raise the flag
    for (int i = 0; i < 5; i++) emptyLine();
    expErr = 1'b0;
    frame(4, 3, 12, 5, 0, 2'b00, "R1");
    frame(8, 4, 8, 6, 0, 2'b01, "R2");
    // R3: partial triplets dropped at line end
    frame(2, 3, 14, 4, 2, 2'b10, "R3");
    frame(3, 3, 13, 2, 1, 2'b10, "R3");
    // R4: enables ignored, timing still followed
    frame(5, 3, 11, 4, 0, 2'b11, "R4");
    frame(6, 2, 10, 3, 0, 2'b00, "R1");
    // R8: porch sweep around every limit
    for (int bp = 0; bp <= 16; bp++) begin
      for (int d = -1; d <= 1; d++) begin
        if (16 - bp + d >= 0) frame(bp, 2, 16 - bp + d, 1, 0, 2'b00, "R1");
      end
    end
    // R8: display length bound
    frame(8, 320, 8, 1, 0, 2'b00, "R6");
    frame(8, 321, 8, 1, 0, 2'b00, "R6");
    frame(7, 2, 9, 2, 0, 2'b00, "R1");
    cyc(1'b1, 1'b0, 1'b0, 18'h0);
    checkErr("R8");
    repeat (4) cyc(1'b0, 1'b0, 1'b0, 18'h0);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R1 missing pixels got %0d left expected 0", expQ.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule